// File: doc/BRIEF.md
# Modulo Post-Modify Address Generator

This block produces data-memory addresses for a small signal-processing controller. It holds two 8-bit pointer registers and two 8-bit modulus registers. On each access, the instruction names one pointer, a step mode and one modulus register. The block presents the pointer's present value on `mem_addr`. One cycle later the pointer holds its stepped value. The step is one of four: plus one, minus one, plus one with wraparound against the selected modulus, or minus one with wraparound against it.

A complex sample keeps its real part in one 256-word memory and its imaginary part in a second one, at the same location. A single `mem_addr` therefore feeds the address inputs of both memories. A host write port loads any of the four registers. Both pointer values are always visible on `ptr_bus`, so they can be read as addresses in the same cycle. This allows circular buffers for filter loops to be walked with no software wraparound checks.

Top module: `modulo_agu`

## Requirements
- R1: After a cycle with `rst` high, both pointers and both moduli read 0, so `ptr_bus` is 0 and `mem_addr` is 0.
- R2: `mem_addr` shows, in the same cycle and without a clock edge, the current value of the pointer selected by `acc_ptr` (0 selects pointer 0, 1 selects pointer 1). A post-modify takes effect only at the next rising edge.
- R3: When `acc_valid` is high and `acc_mode` is 2'b00, the selected pointer becomes its value plus one, modulo 256 (255 steps to 0).
- R4: When `acc_mode` is 2'b01, the pointer becomes its value minus one, modulo 256 (0 steps to 255).
- R5: When `acc_mode` is 2'b10, the pointer becomes 0 if it equals N-1, and otherwise becomes its value plus one. N is the selected modulus.
- R6: When `acc_mode` is 2'b11, the pointer becomes N-1 if it equals 0, and otherwise becomes its value minus one.
- R7: A modulus value of 0 stands for 256, so the modulo modes then give the same result as the plain modes.
- R8: `acc_nsel` chooses the modulus (0 selects modulus 0, 1 selects modulus 1). The modulus used in a step is the value held before any write in the same cycle.
- R9: When `host_we` is high, `host_wdata` is written at the next edge into the register chosen by `host_sel`: 2'b00 pointer 0, 2'b01 pointer 1, 2'b10 modulus 0, 2'b11 modulus 1.
- R10: A host write to a pointer takes priority over a post-modify of that same pointer in the same cycle.
- R11: Only the pointer named by `acc_ptr` is modified; the other pointer keeps its value. `ptr_bus[7:0]` shows pointer 0 and `ptr_bus[15:8]` shows pointer 1.
- R12: When `acc_valid` is low and no host write targets a register, that register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe: step the selected pointer |
| acc_ptr | input | 1 | Pointer used for the access |
| acc_mode | input | 2 | Step mode (00 +1, 01 -1, 10 +1 mod N, 11 -1 mod N) |
| acc_nsel | input | 1 | Modulus register used by modulo modes |
| host_we | input | 1 | Host register write enable |
| host_sel | input | 2 | Host target: {is_modulus, index} |
| host_wdata | input | 8 | Host write data |
| mem_addr | output | 8 | Address for both the real and imaginary memories |
| ptr_bus | output | 16 | Both pointer values, pointer 1 in the upper byte |

## Verification
Some rules hold on every cycle, and in-line properties check them there:
- Registers that are not targeted keep their value.
- A host load lands on the register it names and wins over a post-modify.
- A plain increment follows the emitted address.
- The two modulo wrap points step to 0 and to N-1.

Other behaviour can only be seen in scenarios, and the bench drives those against a reference model:
- A zero modulus acting as 256.
- The modulus being sampled before a same-cycle host write.
- Pointers above the modulus stepping plainly.
- Long random mixes of modes, moduli and host writes.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W  = 8;
    localparam int PTR_CNT = 2;
    localparam int MOD_CNT = 2;
    localparam int PSEL_W  = (PTR_CNT > 1) ? $clog2(PTR_CNT) : 1;
    localparam int MSEL_W  = (MOD_CNT > 1) ? $clog2(MOD_CNT) : 1;
    localparam int IDX_W   = (PSEL_W > MSEL_W) ? PSEL_W : MSEL_W;
    localparam int HSEL_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        STEP_INC     = 2'b00,
        STEP_DEC     = 2'b01,
        STEP_INC_MOD = 2'b10,
        STEP_DEC_MOD = 2'b11
    } step_e;

    typedef struct packed {
        logic              valid;
        logic [PSEL_W-1:0] ptr;
        step_e             mode;
        logic [MSEL_W-1:0] nsel;
    } acc_req_t;

    typedef struct packed {
        logic             we;
        logic             is_mod;
        logic [IDX_W-1:0] idx;
        logic [ADDR_W-1:0] data;
    } host_wr_t;

endpackage

// File: rtl/agu_step.sv
module agu_step
    import agu_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] modulus,
    input  step_e        mode,
    output logic [W-1:0] nxt
);

    // modulus 0 wraps to all-ones, which makes the modulo limit equal the natural one
    logic [W-1:0] lim;
    logic [W-1:0] up;
    logic [W-1:0] dn;

    always_comb begin
        lim = modulus - W'(1);
        up  = cur + W'(1);
        dn  = cur - W'(1);
        unique case (mode)
            STEP_INC:     nxt = up;
            STEP_DEC:     nxt = dn;
            STEP_INC_MOD: nxt = (cur == lim) ? '0 : up;
            STEP_DEC_MOD: nxt = (cur == '0) ? lim : dn;
            default:      nxt = up;
        endcase
    end

endmodule

// File: rtl/agu_regbank.sv
module agu_regbank #(
    parameter int W   = 8,
    parameter int CNT = 2,
    parameter int IW  = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic                  upd_en,
    input  logic [IW-1:0]         upd_idx,
    input  logic [W-1:0]          upd_data,
    output logic [CNT-1:0][W-1:0] q
);

    for (genvar i = 0; i < CNT; i++) begin : g_reg
        logic wr_hit;
        logic upd_hit;

        assign wr_hit  = wr_en  && (wr_idx  == IW'(i));
        assign upd_hit = upd_en && (upd_idx == IW'(i));

        // host load is checked first, so it wins over a step of the same entry
        always_ff @(posedge clk) begin
            if (rst)          q[i] <= '0;
            else if (wr_hit)  q[i] <= wr_data;
            else if (upd_hit) q[i] <= upd_data;
        end

        p_host_load_r9: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IW'(i)) |=> (q[i] == $past(wr_data)));

        p_host_wins_r10: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IW'(i) && upd_en && upd_idx == IW'(i))
            |=> (q[i] == $past(wr_data)));

        p_step_lands_r2: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_idx == IW'(i)) && upd_en && upd_idx == IW'(i))
            |=> (q[i] == $past(upd_data)));

        p_hold_r12: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_idx == IW'(i)) && !(upd_en && upd_idx == IW'(i)))
            |=> $stable(q[i]));
    end

endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
    import agu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic [PSEL_W-1:0]           acc_ptr,
    input  logic [1:0]                  acc_mode,
    input  logic [MSEL_W-1:0]           acc_nsel,
    input  logic                        host_we,
    input  logic [HSEL_W-1:0]           host_sel,
    input  logic [ADDR_W-1:0]           host_wdata,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [PTR_CNT*ADDR_W-1:0]   ptr_bus
);

    acc_req_t req;
    host_wr_t hw;

    assign req.valid = acc_valid;
    assign req.ptr   = acc_ptr;
    assign req.mode  = step_e'(acc_mode);
    assign req.nsel  = acc_nsel;

    assign hw.we     = host_we;
    assign hw.is_mod = host_sel[HSEL_W-1];
    assign hw.idx    = host_sel[IDX_W-1:0];
    assign hw.data   = host_wdata;

    logic [PTR_CNT-1:0][ADDR_W-1:0] ptr_q;
    logic [MOD_CNT-1:0][ADDR_W-1:0] mod_q;
    logic [ADDR_W-1:0]              sel_mod;
    logic [ADDR_W-1:0]              step_val;

    agu_regbank #(.W(ADDR_W), .CNT(PTR_CNT), .IW(PSEL_W)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hw.we && !hw.is_mod),
        .wr_idx   (hw.idx[PSEL_W-1:0]),
        .wr_data  (hw.data),
        .upd_en   (req.valid),
        .upd_idx  (req.ptr),
        .upd_data (step_val),
        .q        (ptr_q)
    );

    agu_regbank #(.W(ADDR_W), .CNT(MOD_CNT), .IW(MSEL_W)) u_mods (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hw.we && hw.is_mod),
        .wr_idx   (hw.idx[MSEL_W-1:0]),
        .wr_data  (hw.data),
        .upd_en   (1'b0),
        .upd_idx  ('0),
        .upd_data ('0),
        .q        (mod_q)
    );

    assign mem_addr = ptr_q[req.ptr];
    assign sel_mod  = mod_q[req.nsel];

    agu_step #(.W(ADDR_W)) u_step (
        .cur     (mem_addr),
        .modulus (sel_mod),
        .mode    (req.mode),
        .nxt     (step_val)
    );

    assign ptr_bus = ptr_q;

    logic no_clash;
    assign no_clash = !(host_we && !host_sel[HSEL_W-1]
                        && host_sel[PSEL_W-1:0] == acc_ptr);

    p_plain_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'b00 && no_clash)
        |=> (ptr_q[$past(acc_ptr)] == ADDR_W'($past(mem_addr) + 1'b1)));

    p_plain_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'b01 && no_clash)
        |=> (ptr_q[$past(acc_ptr)] == ADDR_W'($past(mem_addr) - 1'b1)));

    p_mod_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'b10 && no_clash
         && mem_addr == ADDR_W'(sel_mod - 1'b1))
        |=> (ptr_q[$past(acc_ptr)] == '0));

    p_mod_wrap_dn_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'b11 && no_clash && mem_addr == '0)
        |=> (ptr_q[$past(acc_ptr)] == ADDR_W'($past(sel_mod) - 1'b1)));

endmodule

// File: tb/modulo_agu_bench.sv
`timescale 1ns/1ps
module modulo_agu_bench;

    logic       clk;
    logic       rst;
    logic       acc_valid;
    logic       acc_ptr;
    logic [1:0] acc_mode;
    logic       acc_nsel;
    logic       host_we;
    logic [1:0] host_sel;
    logic [7:0] host_wdata;
    logic [7:0] mem_addr;
    logic [15:0] ptr_bus;

    int n_chk;
    int n_bad;
    logic [7:0] mp [2];
    logic [7:0] mn [2];

    modulo_agu u_modulo_agu (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ptr(acc_ptr),
        .acc_mode(acc_mode), .acc_nsel(acc_nsel), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata),
        .mem_addr(mem_addr), .ptr_bus(ptr_bus)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference step written from the requirement text
    function automatic logic [7:0] ref_step(input logic [7:0] cur, input logic [1:0] mode,
                                           input logic [7:0] nreg);
        int m;
        int c;
        m = (nreg == 8'd0) ? 256 : int'(nreg);
        c = int'(cur);
        case (mode)
            2'b00: return 8'((c + 1) % 256);
            2'b01: return 8'((c + 255) % 256);
            2'b10: return (c == m - 1) ? 8'd0 : 8'((c + 1) % 256);
            default: return (c == 0) ? 8'(m - 1) : 8'(c - 1);
        endcase
    endfunction

    // call just after a falling edge
    task automatic apply(input bit v, input bit p, input logic [1:0] m, input bit n,
                         input bit hwe, input logic [1:0] hs, input logic [7:0] hd,
                         input string tag);
        logic [7:0] ep [2];
        logic [7:0] en [2];
        acc_valid = v; acc_ptr = p; acc_mode = m; acc_nsel = n;
        host_we = hwe; host_sel = hs; host_wdata = hd;
        #1;
        chk(mem_addr == mp[p], "R2 address is current pointer", int'(mem_addr), int'(mp[p]));
        ep = mp;
        en = mn;
        if (v) ep[p] = ref_step(mp[p], m, mn[n]);
        if (hwe) begin
            if (hs[1]) en[hs[0]] = hd;
            else       ep[hs[0]] = hd;
        end
        @(posedge clk);
        @(negedge clk);
        mp = ep;
        mn = en;
        chk(ptr_bus == {mp[1], mp[0]}, tag, int'(ptr_bus), int'({mp[1], mp[0]}));
    endtask

    task automatic hload(input logic [1:0] hs, input logic [7:0] hd);
        apply(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, hs, hd, "R9 host load");
    endtask

    string mtag [4] = '{"R3 plain inc", "R4 plain dec", "R5 mod inc", "R6 mod dec"};

    initial begin
        n_chk = 0;
        n_bad = 0;
        void'($urandom(32'd20240611));
        rst = 1'b1; acc_valid = 1'b0; acc_ptr = 1'b0; acc_mode = 2'b00;
        acc_nsel = 1'b0; host_we = 1'b0; host_sel = 2'b00; host_wdata = 8'd0;
        mp[0] = 8'd0; mp[1] = 8'd0; mn[0] = 8'd0; mn[1] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ptr_bus == 16'd0, "R1 reset pointers", int'(ptr_bus), 0);
        chk(mem_addr == 8'd0, "R1 reset address", int'(mem_addr), 0);

        // R1 moduli reset to 0 (=256): modulo dec from 0 reaches 255
        apply(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 8'd0, "R1 R7 reset modulus acts as 256");

        // R3 / R4 natural wrap
        hload(2'b00, 8'd255);
        apply(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 8'd0, "R3 inc 255 to 0");
        hload(2'b01, 8'd0);
        apply(1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00, 8'd0, "R4 dec 0 to 255");

        // R5 wrap at N-1, R8 select modulus 0
        hload(2'b10, 8'd5);
        hload(2'b11, 8'd7);
        hload(2'b00, 8'd3);
        apply(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 8'd0, "R5 mod inc 3 to 4");
        apply(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 8'd0, "R5 R8 mod inc 4 wraps to 0 (N0=5)");
        // R6 wrap at 0 with modulus 1, R8
        hload(2'b01, 8'd0);
        apply(1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 2'b00, 8'd0, "R6 R8 mod dec 0 wraps to 6 (N1=7)");
        apply(1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 2'b00, 8'd0, "R6 mod dec 6 to 5");

        // R7 zero modulus behaves like plain
        hload(2'b10, 8'd0);
        hload(2'b00, 8'd255);
        apply(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 8'd0, "R7 zero modulus inc 255 to 0");

        // R8 modulus sampled before same-cycle write to it
        hload(2'b10, 8'd4);
        hload(2'b00, 8'd0);
        apply(1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 2'b10, 8'd9, "R8 old modulus used (0 to 3)");
        apply(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 8'd0, "R8 new modulus visible (3 to 2)");

        // R10 host write wins
        apply(1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 2'b01, 8'd77, "R10 host write beats step");
        // R11 step one pointer while host writes the other
        apply(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b01, 8'd12, "R11 other pointer loaded, named stepped");
        apply(1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00, 8'd0, "R11 only named pointer moves");
        // R12 idle
        apply(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 8'd0, "R12 idle holds");
        apply(1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 2'b00, 8'd0, "R12 idle holds");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            bit         v;
            bit         p;
            logic [1:0] m;
            bit         n;
            bit         hwe;
            logic [1:0] hs;
            logic [7:0] hd;
            v   = ($urandom_range(0, 9) != 0);
            p   = 1'($urandom_range(0, 1));
            m   = 2'($urandom_range(0, 3));
            n   = 1'($urandom_range(0, 1));
            hwe = ($urandom_range(0, 9) == 0);
            hs  = 2'($urandom_range(0, 3));
            hd  = hs[1] ? 8'($urandom_range(0, 12)) : 8'($urandom_range(0, 255));
            if (hwe) apply(v, p, m, n, hwe, hs, hd, "R9 R10 random host write");
            else if (!v) apply(v, p, m, n, hwe, hs, hd, "R12 random idle");
            else apply(v, p, m, n, hwe, hs, hd, mtag[m]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule